// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

The block is a watchdog counter for a system that must be brought back if its software stops making progress. It counts tick enables taken from one of several slow clock sources, each of which is presented as a one-cycle tick input in the system clock domain. If software does not restart the count before one of eight programmable periods has passed, the watchdog expires. On expiry it sets a sticky timeout flag and issues a one-cycle wake pulse, so that a sleeping system's power controller can resume the core. Depending on the configured action it also raises an interrupt, requests a system reset at once, or raises the interrupt first and requests the reset only if software still has not restarted the count after a fixed grace window.

Software drives a small register port. A write strobe loads the enable, period select, action select and clock source select together. Separate strobes restart the count and clear the timeout flag. The enable state after reset is not fixed in the RTL. It comes from a configuration input, so a product can be built to have the watchdog running from power-on.

Top module: `wdt_top`

## Requirements
- R1: With period select n (0 to 7) and the watchdog enabled from a zero count, expiry happens on the edge that counts the 2^(4+2n)-th tick of the selected source: 16, 64, 256, ... ticks. The count then wraps to zero and keeps running.
- R2: Only the tick input chosen by the source select (index 0 to 3) advances the count. Ticks on the other inputs have no effect.
- R3: After reset the enable equals `boot_enable`. The reset defaults are period select 2 (256 ticks), action 2'b01 and source 0. While disabled, the count is held at zero and ticks neither expire nor advance it.
- R4: A pulse on `kick` sets the count to zero on the next edge and wins over a tick in the same cycle. It also cancels a pending grace window.
- R5: A configuration write that changes the period select sets the count to zero, so the full new period must elapse before expiry.
- R6: `timeout_flag` is set on expiry and stays set until `flag_clear` is pulsed. An expiry in the same cycle as `flag_clear` leaves the flag set.
- R7: The action select bit 0 enables the interrupt: `irq` is high exactly while the timeout flag is set and bit 0 is one.
- R8: The action select bit 1 enables the reset request. With action 2'b10, `reset_req` goes high in the cycle after the expiring edge and stays high for exactly 4 system clocks.
- R9: With action 2'b11, expiry starts a grace window. `reset_req` begins its 4-clock pulse after 1024 further ticks of the selected source unless `kick` arrives first. Later expiries inside the window do not restart it.
- R10: Every expiry produces a one-cycle `wake` pulse in the cycle after the expiring edge, whatever the action, including action 2'b00.
- R11: During and after reset, `timeout_flag`, `irq`, `reset_req` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_enable | input | 1 | Enable state loaded by reset |
| tick_in | input | 4 | One-cycle tick enables, one per clock source |
| cfg_we | input | 1 | Loads the four configuration fields below |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_period | input | 3 | Period select n, timeout 2^(4+2n) ticks |
| cfg_action | input | 2 | Bit 0 interrupt, bit 1 reset request |
| cfg_src | input | 2 | Tick source index |
| kick | input | 1 | Restart strobe from software |
| flag_clear | input | 1 | Clears the sticky timeout flag |
| timeout_flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |
| reset_req | output | 1 | System reset request pulse |
| wake | output | 1 | Wake-up pulse on expiry |

## Verification
Several properties are checked on every cycle:
- the count stays within the selected period;
- a disabled watchdog and a kicked watchdog hold a zero count;
- the wake pulse is a single cycle and comes with a set flag;
- the flag stays set until it is cleared;
- every reset request lasts exactly four clocks.

Other behaviour only shows up in the bench scenarios: the exact tick on which each period expires under random tick gaps and noise on the other sources, the 1024-tick grace window and its cancellation by a kick, the boot-enable default, and the flag surviving a clear in its set cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PER_W       = 3;
    localparam int BASE_EXP    = 4;
    localparam int STEP_EXP    = 2;
    localparam int MAX_EXP     = BASE_EXP + STEP_EXP * ((1 << PER_W) - 1);
    localparam int CNT_W       = MAX_EXP;
    localparam int GRACE_TICKS = 1024;
    localparam int GRACE_W     = $clog2(GRACE_TICKS);
    localparam int PULSE_LEN   = 4;
    localparam int PULSE_W     = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic rst_en;
        logic irq_en;
    } act_t;

    typedef struct packed {
        logic             en;
        logic [PER_W-1:0] period;
        act_t             action;
    } cfg_t;

    function automatic logic [CNT_W-1:0] period_last(input logic [PER_W-1:0] sel);
        int          e;
        logic [63:0] full;
        e    = BASE_EXP + STEP_EXP * int'(sel);
        full = (64'd1 << e) - 64'd1;
        return full[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_SRC-1:0] tick_in,
    input  logic [SRC_W-1:0]   src,
    output logic               tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (SRC_W'(i) == src) tick = tick_in[i];
        end
    end
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_pkg::*;
#(
    parameter int               SRC_W      = 2,
    parameter logic [PER_W-1:0] DEF_PERIOD = 3'd2,
    parameter logic [1:0]       DEF_ACTION = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_enable,
    input  logic             cfg_we,
    input  logic             cfg_enable,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [1:0]       cfg_action,
    input  logic [SRC_W-1:0] cfg_src,
    output cfg_t             cfg_q,
    output logic [SRC_W-1:0] src_q,
    output logic             period_chg
);
    assign period_chg = cfg_we && (cfg_period != cfg_q.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en     <= boot_enable;
            cfg_q.period <= DEF_PERIOD;
            cfg_q.action <= act_t'(DEF_ACTION);
            src_q        <= '0;
        end else if (cfg_we) begin
            cfg_q.en     <= cfg_enable;
            cfg_q.period <= cfg_period;
            cfg_q.action <= act_t'(cfg_action);
            src_q        <= cfg_src;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    assign expire = en && !restart && tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !en || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic kick,
    input  logic expire,
    input  logic flag_clear,
    input  act_t action,
    output logic flag_q,
    output logic irq,
    output logic reset_req,
    output logic wake_q
);
    logic               grace_q;
    logic [GRACE_W-1:0] grace_cnt_q;
    logic [PULSE_W-1:0] pulse_q;
    logic               grace_done;
    logic               fire;
    logic               grace_start;

    assign grace_done  = grace_q && en && tick && !kick
                         && (grace_cnt_q == GRACE_W'(GRACE_TICKS - 1));
    assign grace_start = expire && action.rst_en && action.irq_en && !grace_q;
    assign fire        = (expire && action.rst_en && !action.irq_en) || grace_done;

    always_ff @(posedge clk) begin
        if (rst || kick || !en) begin
            grace_q     <= 1'b0;
            grace_cnt_q <= '0;
        end else if (grace_start) begin
            grace_q     <= 1'b1;
            grace_cnt_q <= '0;
        end else if (grace_done) begin
            grace_q     <= 1'b0;
            grace_cnt_q <= '0;
        end else if (grace_q && tick) begin
            grace_cnt_q <= grace_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else if (fire) begin
            pulse_q <= PULSE_W'(PULSE_LEN);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= expire;
            if (expire)          flag_q <= 1'b1;
            else if (flag_clear) flag_q <= 1'b0;
        end
    end

    assign irq       = flag_q && action.irq_en;
    assign reset_req = (pulse_q != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int               NUM_SRC    = 4,
    parameter logic [PER_W-1:0] DEF_PERIOD = 3'd2,
    parameter logic [1:0]       DEF_ACTION = 2'b01,
    localparam int              SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_enable,
    input  logic [NUM_SRC-1:0] tick_in,
    input  logic               cfg_we,
    input  logic               cfg_enable,
    input  logic [PER_W-1:0]   cfg_period,
    input  logic [1:0]         cfg_action,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic               kick,
    input  logic               flag_clear,
    output logic               timeout_flag,
    output logic               irq,
    output logic               reset_req,
    output logic               wake
);
    cfg_t             cfg_q;
    logic [SRC_W-1:0] src_q;
    logic             period_chg;
    logic             tick_sel;
    logic             restart;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_last;
    logic             expire;

    wdt_cfg_regs #(
        .SRC_W      (SRC_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_ACTION (DEF_ACTION)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .boot_enable (boot_enable),
        .cfg_we      (cfg_we),
        .cfg_enable  (cfg_enable),
        .cfg_period  (cfg_period),
        .cfg_action  (cfg_action),
        .cfg_src     (cfg_src),
        .cfg_q       (cfg_q),
        .src_q       (src_q),
        .period_chg  (period_chg)
    );

    wdt_tick_sel #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_sel (
        .tick_in (tick_in),
        .src     (src_q),
        .tick    (tick_sel)
    );

    assign restart  = kick || period_chg;
    assign cnt_last = period_last(cfg_q.period);

    wdt_counter u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_q.en),
        .tick    (tick_sel),
        .restart (restart),
        .last    (cnt_last),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

    wdt_action u_act (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_q.en),
        .tick       (tick_sel),
        .kick       (kick),
        .expire     (expire),
        .flag_clear (flag_clear),
        .action     (cfg_q.action),
        .flag_q     (timeout_flag),
        .irq        (irq),
        .reset_req  (reset_req),
        .wake_q     (wake)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             kick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cnt_last,
    input logic             timeout_flag,
    input logic             flag_clear,
    input logic             reset_req,
    input logic             wake
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= '0;
        else if (reset_req) run_q <= run_q + 3'd1;
        else                run_q <= '0;
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cnt_last);

    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    p_kick_zero_r4: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !flag_clear) |=> timeout_flag);

    p_wake_flag_r10: assert property (@(posedge clk) disable iff (rst)
        wake |-> timeout_flag);

    p_wake_single_r10: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    p_pulse_max_r8: assert property (@(posedge clk) disable iff (rst)
        (run_q == 3'd4) |-> !reset_req);

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_req) |-> ($past(run_q) == 3'd3));
endmodule

bind wdt_top wdt_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (cfg_q.en),
    .kick         (kick),
    .cnt_q        (cnt_q),
    .cnt_last     (cnt_last),
    .timeout_flag (timeout_flag),
    .flag_clear   (flag_clear),
    .reset_req    (reset_req),
    .wake         (wake)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_enable = 1'b0;
    logic [3:0] tick_in = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [2:0] cfg_period = '0;
    logic [1:0] cfg_action = '0;
    logic [1:0] cfg_src = '0;
    logic       kick = 1'b0;
    logic       flag_clear = 1'b0;
    logic       timeout_flag, irq, reset_req, wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wdt_top uut (
        .clk(clk), .rst(rst), .boot_enable(boot_enable), .tick_in(tick_in),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_period(cfg_period),
        .cfg_action(cfg_action), .cfg_src(cfg_src), .kick(kick),
        .flag_clear(flag_clear), .timeout_flag(timeout_flag), .irq(irq),
        .reset_req(reset_req), .wake(wake)
    );

    function automatic int ticks_for(input int sel);
        return 1 << (4 + 2 * sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in = '0;
            @(negedge clk);
        end
    endtask

    // n ticks on source src, random gaps, random noise on other sources
    task automatic tick_n(input int n, input int src);
        logic [3:0] mask;
        mask = ~(4'b0001 << src);
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                tick_in = 4'($urandom) & mask;
                @(negedge clk);
            end
            tick_in = (4'($urandom) & mask) | ~mask;
            @(negedge clk);
        end
        tick_in = '0;
    endtask

    task automatic noise_only(input int n, input int src);
        logic [3:0] mask;
        mask = ~(4'b0001 << src);
        for (int i = 0; i < n; i++) begin
            tick_in = 4'($urandom) & mask;
            @(negedge clk);
        end
        tick_in = '0;
    endtask

    task automatic do_reset(input logic boot);
        boot_enable = boot;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic en, input int per, input int act, input int src);
        cfg_we     = 1'b1;
        cfg_enable = en;
        cfg_period = 3'(per);
        cfg_action = 2'(act);
        cfg_src    = 2'(src);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        tick_in = 4'b1111;
        @(negedge clk);
        kick = 1'b0;
        tick_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);

        // R11 reset state
        do_reset(1'b0);
        check("R11 flag", timeout_flag, 0);
        check("R11 irq", irq, 0);
        check("R11 reset_req", reset_req, 0);
        check("R11 wake", wake, 0);

        // R3 boot disabled: ticks ignored
        tick_n(300, 0);
        check("R3 boot disabled flag", timeout_flag, 0);

        // R3 boot enabled with defaults (period 2, action 01, source 0)
        do_reset(1'b1);
        tick_n(ticks_for(2) - 1, 0);
        check("R3 R1 before default expiry", timeout_flag, 0);
        tick_n(1, 0);
        check("R3 R1 default expiry", timeout_flag, 1);
        check("R10 wake pulse", wake, 1);
        check("R7 irq default action", irq, 1);
        idle(1);
        check("R10 wake single", wake, 0);

        // R1 R2 random source over periods 0..3
        for (int p = 0; p < 4; p++) begin
            int s;
            s = $urandom % 4;
            do_reset(1'b0);
            write_cfg(1'b1, p, 1, s);
            tick_n(ticks_for(p) - 1, s);
            check("R1 R2 no early expiry", timeout_flag, 0);
            tick_n(1, s);
            check("R1 R2 expiry on last tick", timeout_flag, 1);
        end

        // R2 ticks only on other sources
        do_reset(1'b0);
        write_cfg(1'b1, 0, 1, 2);
        noise_only(2000, 2);
        check("R2 other sources ignored", timeout_flag, 0);

        // R4 kick restarts, wins over same-cycle tick
        do_reset(1'b0);
        write_cfg(1'b1, 0, 1, 1);
        tick_n(15, 1);
        do_kick();
        tick_n(15, 1);
        check("R4 kick restarted count", timeout_flag, 0);
        tick_n(1, 1);
        check("R4 expiry after kick", timeout_flag, 1);

        // R5 period change clears count
        do_reset(1'b0);
        write_cfg(1'b1, 1, 1, 0);
        tick_n(60, 0);
        write_cfg(1'b1, 0, 1, 0);
        tick_n(15, 0);
        check("R5 no expiry after period change", timeout_flag, 0);
        tick_n(1, 0);
        check("R5 expiry at new period", timeout_flag, 1);

        // R6 sticky flag and clear
        idle(5);
        check("R6 flag sticky", timeout_flag, 1);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
        check("R6 flag cleared", timeout_flag, 0);
        check("R7 irq follows flag", irq, 0);
        tick_n(15, 0);
        flag_clear = 1'b1;
        tick_n(1, 0);
        flag_clear = 1'b0;
        check("R6 set wins over clear", timeout_flag, 1);

        // R7 R10 action 00: flag and wake only
        do_reset(1'b0);
        write_cfg(1'b1, 0, 0, 3);
        tick_n(16, 3);
        check("R7 action00 flag", timeout_flag, 1);
        check("R7 action00 no irq", irq, 0);
        check("R10 action00 wake", wake, 1);
        for (int i = 0; i < 20; i++) begin
            check("R8 action00 no reset", reset_req, 0);
            idle(1);
        end

        // R8 action 10: immediate 4-clock reset pulse
        do_reset(1'b0);
        write_cfg(1'b1, 0, 2, 0);
        tick_n(15, 0);
        check("R8 no reset before expiry", reset_req, 0);
        tick_n(1, 0);
        for (int i = 0; i < 4; i++) begin
            check("R8 pulse high", reset_req, 1);
            idle(1);
        end
        check("R8 pulse ends", reset_req, 0);
        check("R7 action10 no irq", irq, 0);

        // R9 action 11: reset after 1024 grace ticks
        do_reset(1'b0);
        write_cfg(1'b1, 0, 3, 0);
        tick_n(16, 0);
        check("R9 irq first", irq, 1);
        check("R9 no reset yet", reset_req, 0);
        tick_n(1023, 0);
        check("R9 reset not before grace", reset_req, 0);
        tick_n(1, 0);
        check("R9 reset after grace", reset_req, 1);

        // R9 R4 kick cancels pending grace
        do_reset(1'b0);
        write_cfg(1'b1, 3, 3, 1);
        tick_n(1024, 1);
        check("R9 irq at period 3", irq, 1);
        tick_n(500, 1);
        do_kick();
        tick_n(1023, 1);
        check("R9 R4 kick cancelled grace", reset_req, 0);
        tick_n(1, 1);
        check("R10 wake on re-expiry", wake, 1);
        check("R9 new grace no reset", reset_req, 0);

        // R3 disable holds count, re-enable needs full period
        do_reset(1'b0);
        write_cfg(1'b1, 0, 1, 0);
        tick_n(10, 0);
        write_cfg(1'b0, 0, 1, 0);
        tick_n(2000, 0);
        check("R3 disabled no expiry", timeout_flag, 0);
        write_cfg(1'b1, 0, 1, 0);
        tick_n(15, 0);
        check("R3 count held at zero", timeout_flag, 0);
        tick_n(1, 0);
        check("R3 expiry after re-enable", timeout_flag, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule